// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block sits beside a CPU core and decides which interrupt the core takes next. It watches a set of level-sensitive maskable request lines and one non-maskable input. Each maskable source has its own enable bit and a one-bit priority level. Among the enabled requests the block picks a winner: high level first, then a fixed order by source index. It then tests the winner against the core's two mask bits: the main mask and a second mask that shuts out only the low level.

A request that passes the mask is taken only when the core reports that the current instruction has finished. On acceptance the block emits a one-cycle accept pulse and a vector address for the taken source. In the same cycle it asserts two update strobes that tell the core to set both mask bits. A maskable request that is blocked or loses arbitration stays pending for as long as its source holds it. The non-maskable input is edge-detected, and it always wins.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `accept`, `set_mask_i` and `set_mask_ui` are 0 and `vec_addr` is 0.
- R2: A maskable source takes part in arbitration only when both its request bit and its enable bit are 1. A disabled source is never accepted, even when no other request exists.
- R3: A request with level bit 1 beats any request with level bit 0, whatever the source indices.
- R4: Among requests of equal level, the lowest source index wins.
- R5: With `mask_i` = 0, the winning maskable request is accepted whatever its level and whatever `mask_ui`.
- R6: With `mask_i` = 1 and `mask_ui` = 0, only the NMI and level-1 requests are accepted. A level-0 winner produces no acceptance.
- R7: With `mask_i` = 1 and `mask_ui` = 1, only the NMI is accepted.
- R8: Acceptance happens only at a clock edge where `insn_done` is 1. The accept pulse appears in the cycle after that edge.
- R9: `accept` lasts one cycle for each acceptance. `set_mask_i` and `set_mask_ui` are both 1 in exactly the cycles where `accept` is 1.
- R10: `vec_addr` equals VEC_BASE + 4*k. Here k = 0 for the NMI and k = s+1 for maskable source s. The value changes only together with `accept`, and it holds until the next acceptance.
- R11: The NMI is latched on a rising edge of `nmi` and beats every maskable request. One rising edge yields exactly one acceptance.
- R12: A request blocked by the masks is not lost. It is accepted at the first instruction boundary after the masks allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | N_SRC | Level-sensitive maskable request lines |
| irq_en | input | N_SRC | Per-source enable bits |
| irq_lvl | input | N_SRC | Per-source priority level (1 = high) |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| mask_i | input | 1 | Core main interrupt mask bit |
| mask_ui | input | 1 | Core secondary mask bit (blocks level 0 when mask_i is set) |
| insn_done | input | 1 | Instruction-complete strobe from the core |
| accept | output | 1 | One-cycle acceptance pulse |
| vec_addr | output | ADDR_W | Vector address of the accepted source |
| set_mask_i | output | 1 | Strobe telling the core to set mask_i |
| set_mask_ui | output | 1 | Strobe telling the core to set mask_ui |

## Verification
A maskable request that is present and gated open at a clock edge with `insn_done` high shows up on `accept`, `vec_addr` and both set strobes one cycle later. The NMI costs one more cycle, because its rising edge is first captured in a pending flag. The bench drives every input on the falling edge and reads the outputs on the next falling edge, which lies half a cycle after the edge that registered the result. The NMI sequences leave one extra cycle between the edge and the instruction-complete strobe. Hold and no-acceptance cases are checked in every cycle of the window in which the result could have appeared.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;

  typedef enum logic [1:0] {
    GATE_OPEN      = 2'd0,
    GATE_HIGH_ONLY = 2'd1,
    GATE_NMI_ONLY  = 2'd2
  } gate_mode_e;

  // Map the two core mask bits onto a gating mode.
  function automatic gate_mode_e mode_of(input logic m_i, input logic m_ui);
    if (!m_i)      return GATE_OPEN;
    else if (!m_ui) return GATE_HIGH_ONLY;
    else           return GATE_NMI_ONLY;
  endfunction

  // Does a maskable request of the given level pass the gate?
  function automatic logic level_passes(input gate_mode_e mode, input logic lvl);
    case (mode)
      GATE_OPEN:      return 1'b1;
      GATE_HIGH_ONLY: return lvl;
      default:        return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
`timescale 1ns/1ps
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend,
  output logic rise
);
  logic nmi_prev;

  assign rise = nmi_in & ~nmi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      pend     <= 1'b0;
    end else begin
      nmi_prev <= nmi_in;
      // A fresh edge in the same cycle as a take stays pending.
      pend     <= (pend & ~take) | rise;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int N_SRC = 8,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] en,
  input  logic [N_SRC-1:0] lvl,
  output logic             win_valid,
  output logic [SRC_W-1:0] win_idx,
  output logic             win_lvl
);
  logic [N_SRC-1:0] hi_req;
  logic [N_SRC-1:0] lo_req;
  logic [SRC_W-1:0] hi_idx;
  logic [SRC_W-1:0] lo_idx;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      assign hi_req[g] = req[g] & en[g] &  lvl[g];
      assign lo_req[g] = req[g] & en[g] & ~lvl[g];
    end
  endgenerate

  // Scan downward so that the lowest set index is kept last.
  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (hi_req[k]) hi_idx = SRC_W'(k);
      if (lo_req[k]) lo_idx = SRC_W'(k);
    end
  end

  assign win_lvl   = |hi_req;
  assign win_valid = |hi_req | |lo_req;
  assign win_idx   = win_lvl ? hi_idx : lo_idx;
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate
  import irq_pkg::*;
(
  input  logic mask_i,
  input  logic mask_ui,
  input  logic nmi_pend,
  input  logic win_valid,
  input  logic win_lvl,
  output logic take_nmi,
  output logic take_src,
  output logic grant_ok
);
  gate_mode_e mode;

  assign mode     = mode_of(mask_i, mask_ui);
  assign take_nmi = nmi_pend;
  assign take_src = ~nmi_pend & win_valid & level_passes(mode, win_lvl);
  assign grant_ok = take_nmi | take_src;
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter int              N_SRC    = 8,
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     VEC_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [N_SRC-1:0]  irq_en,
  input  logic [N_SRC-1:0]  irq_lvl,
  input  logic              nmi,
  input  logic              mask_i,
  input  logic              mask_ui,
  input  logic              insn_done,
  output logic              accept,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              set_mask_i,
  output logic              set_mask_ui
);
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int VI_W  = $clog2(N_SRC + 1);

  // Vector slot k sits 4 bytes above slot k-1; slot 0 is the NMI.
  function automatic logic [ADDR_W-1:0] vec_of(input logic [VI_W-1:0] slot);
    return ADDR_W'(VEC_BASE) + (ADDR_W'(slot) << 2);
  endfunction

  // Named internal events
  logic             nmi_pend;
  logic             nmi_rise;
  logic             win_valid;
  logic [SRC_W-1:0] win_idx;
  logic             win_lvl;
  logic             take_nmi;
  logic             take_src;
  logic             grant_ok;
  logic             take_now;
  logic [VI_W-1:0]  grant_slot;
  logic             accept_q;
  logic [ADDR_W-1:0] vec_q;

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi),
    .take   (take_now & take_nmi),
    .pend   (nmi_pend),
    .rise   (nmi_rise)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .req       (irq_req),
    .en        (irq_en),
    .lvl       (irq_lvl),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  irq_gate u_gate (
    .mask_i    (mask_i),
    .mask_ui   (mask_ui),
    .nmi_pend  (nmi_pend),
    .win_valid (win_valid),
    .win_lvl   (win_lvl),
    .take_nmi  (take_nmi),
    .take_src  (take_src),
    .grant_ok  (grant_ok)
  );

  assign take_now   = insn_done & grant_ok;
  assign grant_slot = take_nmi ? '0 : (VI_W'(win_idx) + VI_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept_q <= 1'b0;
      vec_q    <= '0;
    end else begin
      accept_q <= take_now;
      if (take_now) vec_q <= vec_of(grant_slot);
    end
  end

  assign accept      = accept_q;
  assign vec_addr    = vec_q;
  assign set_mask_i  = accept_q;
  assign set_mask_ui = accept_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
`timescale 1ns/1ps
module irq_prio_ctrl_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] VEC_BASE = 16'h0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done,
  input logic              mask_i,
  input logic              mask_ui,
  input logic              accept,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              nmi_pend,
  input logic              win_lvl
);
  localparam logic [ADDR_W-1:0] NMI_VEC = ADDR_W'(VEC_BASE);

  AST_ACC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(insn_done)); // R8

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> $stable(vec_addr)); // R10

  AST_NMI_ONLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $past(mask_i && mask_ui)) |-> vec_addr == NMI_VEC); // R7

  AST_HIGH_ONLY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $past(mask_i && !mask_ui) && vec_addr != NMI_VEC) |-> $past(win_lvl)); // R6

  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $past(nmi_pend)) |-> vec_addr == NMI_VEC); // R11
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_done (insn_done),
  .mask_i    (mask_i),
  .mask_ui   (mask_ui),
  .accept    (accept),
  .vec_addr  (vec_addr),
  .nmi_pend  (nmi_pend),
  .win_lvl   (win_lvl)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  localparam int          NS   = 8;
  localparam int          AW   = 16;
  localparam logic [15:0] BASE = 16'h0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_req = '0, irq_en = '0, irq_lvl = '0;
  logic          nmi = 1'b0, mask_i = 1'b0, mask_ui = 1'b0, insn_done = 1'b0;
  logic          accept, set_mask_i, set_mask_ui;
  logic [AW-1:0] vec_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.N_SRC(NS), .ADDR_W(AW), .VEC_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
    .irq_lvl(irq_lvl), .nmi(nmi), .mask_i(mask_i), .mask_ui(mask_ui),
    .insn_done(insn_done), .accept(accept), .vec_addr(vec_addr),
    .set_mask_i(set_mask_i), .set_mask_ui(set_mask_ui)
  );

  // Expected vector for slot k: base plus four bytes per slot.
  function automatic logic [AW-1:0] exp_vec(input int slot);
    return BASE + AW'(slot * 4);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] req;
    logic [7:0] en;
    logic [7:0] lvl;
    logic       mi;
    logic       mui;
    logic       acc;
    logic [3:0] slot;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TABLE [NV] = '{
    '{8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 4'd0}, // R2 disabled lone request
    '{8'h01, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1, 4'd1}, // R5 level 0 with mask_i clear
    '{8'h81, 8'hFF, 8'h80, 1'b0, 1'b0, 1'b1, 4'd8}, // R3 high level beats lower index
    '{8'h0C, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 4'd3}, // R4 lowest index among equals
    '{8'h0C, 8'hFF, 8'h0C, 1'b1, 1'b0, 1'b1, 4'd3}, // R6 level 1 passes, R4 order
    '{8'h01, 8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 4'd0}, // R6 level 0 blocked
    '{8'h80, 8'hFF, 8'h80, 1'b1, 1'b1, 1'b0, 4'd0}, // R7 level 1 blocked
    '{8'h10, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 mask_ui ignored
    '{8'h30, 8'h20, 8'h10, 1'b0, 1'b0, 1'b1, 4'd6}  // R2 disabled high-level loses
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] last_vec;
    // R1 reset state
    repeat (2) @(negedge clk);
    check(accept == 0 && set_mask_i == 0 && set_mask_ui == 0, "R1 outputs in reset", accept, 0);
    check(vec_addr == 0, "R1 vec in reset", vec_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(accept == 0 && vec_addr == 0, "R1 after release", vec_addr, 0);
    last_vec = vec_addr;

    // Vector table walk: inputs on one falling edge, result on the next.
    insn_done = 1'b1;
    for (int v = 0; v < NV; v++) begin
      irq_req = TABLE[v].req; irq_en = TABLE[v].en; irq_lvl = TABLE[v].lvl;
      mask_i = TABLE[v].mi; mask_ui = TABLE[v].mui;
      @(negedge clk);
      check(accept == TABLE[v].acc, $sformatf("R2-table row %0d accept", v), accept, TABLE[v].acc);
      if (TABLE[v].acc) begin
        check(vec_addr == exp_vec(TABLE[v].slot), $sformatf("R10 row %0d vector", v),
              vec_addr, exp_vec(TABLE[v].slot));
        check(set_mask_i && set_mask_ui, $sformatf("R9 row %0d set strobes", v),
              {set_mask_i, set_mask_ui}, 3);
      end else begin
        check(vec_addr == last_vec, $sformatf("R10 row %0d vector held", v), vec_addr, last_vec);
      end
      last_vec = vec_addr;
    end

    // R8: no acceptance without the instruction-complete strobe
    insn_done = 1'b0; irq_req = 8'h04; irq_en = 8'hFF; irq_lvl = 8'h00;
    mask_i = 1'b0; mask_ui = 1'b0;
    @(negedge clk); // drains any result of the last table row
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(accept == 0, "R8 no accept while insn_done low", accept, 0);
    end
    insn_done = 1'b1;
    @(negedge clk);
    check(accept == 1 && vec_addr == exp_vec(3), "R8 accept at boundary", vec_addr, exp_vec(3));
    insn_done = 1'b0;
    @(negedge clk);
    check(accept == 0 && set_mask_i == 0 && set_mask_ui == 0, "R9 single-cycle pulse", accept, 0);

    // R12: masked request kept, taken once the mask opens
    irq_req = 8'h40; irq_lvl = 8'h00; mask_i = 1'b1; mask_ui = 1'b0; insn_done = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check(accept == 0, "R12 held while masked", accept, 0);
    end
    mask_i = 1'b0;
    @(negedge clk);
    check(accept == 1 && vec_addr == exp_vec(7), "R12 taken when unmasked", vec_addr, exp_vec(7));

    // R11: NMI passes full mask, one edge gives one acceptance
    insn_done = 1'b0; mask_i = 1'b1; mask_ui = 1'b1;
    irq_req = 8'h02; irq_lvl = 8'h02;
    nmi = 1'b1;
    @(negedge clk); // edge latched
    insn_done = 1'b1;
    @(negedge clk);
    check(accept == 1 && vec_addr == exp_vec(0), "R11 NMI accepted under full mask", vec_addr, exp_vec(0));
    @(negedge clk);
    check(accept == 0, "R11 one acceptance per edge", accept, 0);
    @(negedge clk);
    check(accept == 0, "R7 maskable still blocked", accept, 0);

    // R11: NMI beats a high-level maskable request with masks open
    nmi = 1'b0; insn_done = 1'b0; mask_i = 1'b0; mask_ui = 1'b0;
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    insn_done = 1'b1;
    @(negedge clk);
    check(accept == 1 && vec_addr == exp_vec(0), "R11 NMI beats level 1", vec_addr, exp_vec(0));
    @(negedge clk);
    check(accept == 1 && vec_addr == exp_vec(2), "R3 maskable follows NMI", vec_addr, exp_vec(2));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule